// File: doc/BRIEF.md
# Character Display Command Engine

This block is the execution core of a two-row, forty-column-per-row character display controller. It takes one byte per cycle, already framed by an upstream bus adapter. Each byte carries two qualifier bits: whether it is data or an instruction, and whether it is a read or a write. The engine keeps the 7-bit address counter, a flag that says whether that counter points into display RAM or into glyph-pattern RAM, the entry-mode bits, the visible-window offset and the appearance flags. It turns data accesses into write and read strobes, each with an address, toward an external 128-byte display RAM and an external 64-byte pattern RAM.

A clear instruction starts a sequenced fill that writes the space code into every display RAM location, one location per cycle. While the fill runs, `busy` is high and any byte offered is dropped. The window offset comes out as a modulo-40 count, and both rows use the same count. The pixel scanner downstream turns that count into the visible columns.

Read responses come back two cycles after the read is accepted. One cycle is for the registered RAM strobe and one is for the synchronous RAM read. An address-counter read follows the same two-cycle timing, so the adapter upstream sees a single uniform latency.

Top module: `chr_cmd_engine`

## Requirements
- R1: After reset, the engine shows these values: address counter 00H pointing into display RAM, window offset 0, increment mode 1, shift-on-write 0, display, cursor and blink flags 0, 8-bit bus flag 1, two-row flag 1, brightness code 00, `busy` 0 and no strobes.
- R2: An instruction byte is decoded by the position of its highest set bit. The bit positions are: 0 clear, 1 home, 2 entry mode (bit1 increment, bit0 shift-on-write), 3 appearance (bit2 display, bit1 cursor, bit0 blink), 4 cursor/window move (bit3 window, bit2 direction), 5 configuration (bit4 bus width, bit3 rows, bits1:0 brightness), 6 pattern address (bits5:0), 7 display address (bits6:0). The byte 00H changes nothing.
- R3: With the two-row flag set and the counter in display RAM, a counter step increments 27H to 40H and 67H to 00H. It decrements 40H to 27H and 00H to 67H.
- R4: With the two-row flag clear, display addresses wrap between 4FH and 00H in both directions. Pattern addresses always wrap between 3FH and 00H.
- R5: A data write drives a write strobe in the next cycle. The strobe goes to the RAM chosen by the most recent address instruction, carries the old counter value as its address and the byte as write data. The counter steps by the increment-mode bit.
- R6: When shift-on-write is 1, a display RAM write also moves the window. Increment mode 1 adds 1 to the offset and increment mode 0 subtracts 1. Pattern writes and all reads leave the offset unchanged.
- R7: A cursor/window move always steps the counter, up when the direction bit is 1 and down when it is 0. With the window bit set, it also subtracts 1 from the offset (direction 1) or adds 1 (direction 0). Afterwards the counter points into display RAM.
- R8: Clear sets the counter to 00H in display RAM, sets the offset to 0 and sets increment mode to 1. It then holds `busy` high for 128 cycles, during which every byte offered is dropped. In that time it writes 20H to display addresses 00H..7FH in ascending order, one per cycle, starting one cycle after `busy` rises.
- R9: Home sets the counter to 00H in display RAM and the offset to 0. It changes nothing else.
- R10: An address-counter read raises `rd_valid` two cycles after it is accepted, with 0 in bit 7 and the counter in bits 6:0.
- R11: A data read drives a read strobe in the next cycle at the counter address. It raises `rd_valid` one cycle later with the RAM's returned byte, and the counter steps.
- R12: The window offset counts modulo 40: 39 plus one gives 0 and 0 minus one gives 39.
- R13: The appearance and configuration instructions load their flag outputs from the bit positions given in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A byte is offered this cycle |
| cmd_is_data | input | 1 | 1 = data access, 0 = instruction |
| cmd_is_read | input | 1 | 1 = read, 0 = write |
| cmd_byte | input | 8 | Instruction or write data byte |
| busy | output | 1 | Clear fill in progress; offered bytes are dropped |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Read response byte |
| dram_we | output | 1 | Display RAM write strobe |
| dram_re | output | 1 | Display RAM read strobe |
| dram_addr | output | 7 | Display RAM address |
| dram_rdata | input | 8 | Display RAM read data, one cycle after `dram_re` |
| pram_we | output | 1 | Pattern RAM write strobe |
| pram_re | output | 1 | Pattern RAM read strobe |
| pram_addr | output | 6 | Pattern RAM address |
| pram_rdata | input | 8 | Pattern RAM read data, one cycle after `pram_re` |
| mem_wdata | output | 8 | Write data shared by both RAMs |
| cursor_addr | output | 7 | Address counter |
| cursor_in_pattern | output | 1 | Counter points into pattern RAM |
| shift_ofs | output | 6 | Window offset, modulo 40 |
| incr_mode | output | 1 | Counter increments on access |
| shift_on_write | output | 1 | Display writes move the window |
| disp_on | output | 1 | Display enable flag |
| cursor_on | output | 1 | Cursor flag |
| blink_on | output | 1 | Blink flag |
| bus_8bit | output | 1 | Bus width flag for the adapter |
| two_line | output | 1 | Two-row addressing flag |
| bright | output | 2 | Brightness code |

## Verification
The assertions assume that both RAMs return read data exactly one cycle after a read strobe, and that the engine is the only agent driving their strobes. The bench models each RAM as a synchronous array with that latency. The row-range property assumes that the counter enters the two-row map only at valid row addresses. The stimulus loads the counter with addresses inside 00H..27H and 40H..67H whenever two-row mode is active. Bytes are changed only at falling edges, and one byte is offered during a clear to exercise the drop rule.

// File: rtl/chr_pkg.sv
package chr_pkg;

  typedef enum logic [3:0] {
    OP_NOP,
    OP_CLEAR,
    OP_HOME,
    OP_ENTRY,
    OP_APPEAR,
    OP_MOVE,
    OP_CONFIG,
    OP_PADDR,
    OP_DADDR
  } op_e;

  typedef struct packed {
    op_e        op;
    logic       inc;
    logic       sow;
    logic       dsp;
    logic       cur;
    logic       blk;
    logic       win;
    logic       dir;
    logic       wide;
    logic       rows2;
    logic [1:0] lum;
    logic [5:0] paddr;
    logic [6:0] daddr;
  } cmd_t;

endpackage

// File: rtl/chr_cmd_decode.sv
module chr_cmd_decode
  import chr_pkg::*;
(
  input  logic [7:0] cmd_byte_i,
  output cmd_t       cmd_o
);

  always_comb begin
    cmd_o       = '0;
    cmd_o.op    = OP_NOP;
    casez (cmd_byte_i)
      8'b1???????: cmd_o.op = OP_DADDR;
      8'b01??????: cmd_o.op = OP_PADDR;
      8'b001?????: cmd_o.op = OP_CONFIG;
      8'b0001????: cmd_o.op = OP_MOVE;
      8'b00001???: cmd_o.op = OP_APPEAR;
      8'b000001??: cmd_o.op = OP_ENTRY;
      8'b0000001?: cmd_o.op = OP_HOME;
      8'b00000001: cmd_o.op = OP_CLEAR;
      default:     cmd_o.op = OP_NOP;
    endcase
    cmd_o.inc   = cmd_byte_i[1];
    cmd_o.sow   = cmd_byte_i[0];
    cmd_o.dsp   = cmd_byte_i[2];
    cmd_o.cur   = cmd_byte_i[1];
    cmd_o.blk   = cmd_byte_i[0];
    cmd_o.win   = cmd_byte_i[3];
    cmd_o.dir   = cmd_byte_i[2];
    cmd_o.wide  = cmd_byte_i[4];
    cmd_o.rows2 = cmd_byte_i[3];
    cmd_o.lum   = cmd_byte_i[1:0];
    cmd_o.paddr = cmd_byte_i[5:0];
    cmd_o.daddr = cmd_byte_i[6:0];
  end

endmodule

// File: rtl/chr_addr_step.sv
module chr_addr_step #(
  parameter int AC_W          = 7,
  parameter int PAT_W         = 6,
  parameter int LINE_LEN      = 40,
  parameter int LINE2_BASE    = 64,
  parameter int ONE_LINE_SPAN = 80
) (
  input  logic [AC_W-1:0] ac_i,
  input  logic            pattern_i,
  input  logic            two_line_i,
  input  logic            up_i,
  output logic [AC_W-1:0] nxt_o
);

  localparam logic [AC_W-1:0] ROW0_LAST  = AC_W'(LINE_LEN - 1);
  localparam logic [AC_W-1:0] ROW1_FIRST = AC_W'(LINE2_BASE);
  localparam logic [AC_W-1:0] ROW1_LAST  = AC_W'(LINE2_BASE + LINE_LEN - 1);
  localparam logic [AC_W-1:0] ONE_LAST   = AC_W'(ONE_LINE_SPAN - 1);
  localparam logic [AC_W-1:0] ONE_STEP   = AC_W'(1);
  localparam logic [PAT_W-1:0] P_STEP    = PAT_W'(1);

  logic [PAT_W-1:0] p_low;
  logic [PAT_W-1:0] p_nxt;

  assign p_low = ac_i[PAT_W-1:0];
  assign p_nxt = up_i ? (p_low + P_STEP) : (p_low - P_STEP);

  always_comb begin
    if (pattern_i) begin
      nxt_o = {{(AC_W-PAT_W){1'b0}}, p_nxt};
    end else if (two_line_i) begin
      if (up_i) begin
        if (ac_i == ROW0_LAST)      nxt_o = ROW1_FIRST;
        else if (ac_i == ROW1_LAST) nxt_o = '0;
        else                        nxt_o = ac_i + ONE_STEP;
      end else begin
        if (ac_i == ROW1_FIRST)     nxt_o = ROW0_LAST;
        else if (ac_i == '0)        nxt_o = ROW1_LAST;
        else                        nxt_o = ac_i - ONE_STEP;
      end
    end else begin
      if (up_i) nxt_o = (ac_i == ONE_LAST) ? '0 : ac_i + ONE_STEP;
      else      nxt_o = (ac_i == '0) ? ONE_LAST : ac_i - ONE_STEP;
    end
  end

endmodule

// File: rtl/chr_shift_ofs.sv
module chr_shift_ofs #(
  parameter int SPAN = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    left_i,
  input  logic                    right_i,
  output logic [$clog2(SPAN)-1:0] ofs_o
);

  localparam int OW = $clog2(SPAN);
  localparam logic [OW-1:0] TOP = OW'(SPAN - 1);

  logic [OW-1:0] ofs_q, ofs_d;
  logic          ofs_en;

  assign ofs_en = clr_i | left_i | right_i;

  always_comb begin
    ofs_d = ofs_q;
    if (clr_i)        ofs_d = '0;
    else if (left_i)  ofs_d = (ofs_q == TOP) ? '0 : ofs_q + OW'(1);
    else if (right_i) ofs_d = (ofs_q == '0) ? TOP : ofs_q - OW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ofs_q <= '0;
    else if (ofs_en) ofs_q <= ofs_d;
  end

  assign ofs_o = ofs_q;

  assert_ofs_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_q <= TOP);

  assert_ofs_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (left_i && !clr_i && ofs_q == TOP) |=> (ofs_q == '0));

endmodule

// File: rtl/chr_fill_seq.sv
module chr_fill_seq #(
  parameter int DEPTH = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  output logic                     busy_o,
  output logic [$clog2(DEPTH)-1:0] addr_o
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          busy_q, busy_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = start_i | busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + AW'(1);
      if (cnt_q == LAST) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign addr_o = cnt_q;

  assert_fill_ascend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + AW'(1)));

  assert_fill_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == LAST) |=> !busy_q);

endmodule

// File: rtl/chr_cmd_engine.sv
module chr_cmd_engine
  import chr_pkg::*;
#(
  parameter int          AC_W          = 7,
  parameter int          PAT_W         = 6,
  parameter int          DATA_W        = 8,
  parameter int          LINE_LEN      = 40,
  parameter int          LINE2_BASE    = 64,
  parameter int          ONE_LINE_SPAN = 80,
  parameter int          FILL_DEPTH    = 128,
  parameter logic [7:0]  FILL_CHAR     = 8'h20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic                        cmd_is_data,
  input  logic                        cmd_is_read,
  input  logic [DATA_W-1:0]           cmd_byte,
  output logic                        busy,
  output logic                        rd_valid,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        dram_we,
  output logic                        dram_re,
  output logic [AC_W-1:0]             dram_addr,
  input  logic [DATA_W-1:0]           dram_rdata,
  output logic                        pram_we,
  output logic                        pram_re,
  output logic [PAT_W-1:0]            pram_addr,
  input  logic [DATA_W-1:0]           pram_rdata,
  output logic [DATA_W-1:0]           mem_wdata,
  output logic [AC_W-1:0]             cursor_addr,
  output logic                        cursor_in_pattern,
  output logic [$clog2(LINE_LEN)-1:0] shift_ofs,
  output logic                        incr_mode,
  output logic                        shift_on_write,
  output logic                        disp_on,
  output logic                        cursor_on,
  output logic                        blink_on,
  output logic                        bus_8bit,
  output logic                        two_line,
  output logic [1:0]                  bright
);

  localparam int FILL_AW = $clog2(FILL_DEPTH);
  localparam logic [AC_W-1:0] ROW0_LAST  = AC_W'(LINE_LEN - 1);
  localparam logic [AC_W-1:0] ROW1_FIRST = AC_W'(LINE2_BASE);
  localparam logic [AC_W-1:0] ROW1_LAST  = AC_W'(LINE2_BASE + LINE_LEN - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  // decode
  cmd_t dec;
  chr_cmd_decode u_dec (.cmd_byte_i(cmd_byte[7:0]), .cmd_o(dec));

  // clear fill sequencer
  logic               fill_busy;
  logic               fill_start;
  logic [FILL_AW-1:0] fill_addr;

  chr_fill_seq #(.DEPTH(FILL_DEPTH)) u_fill (
    .clk     (clk),
    .rst_n   (rst_sn),
    .start_i (fill_start),
    .busy_o  (fill_busy),
    .addr_o  (fill_addr)
  );

  // window offset
  logic ofs_clr, ofs_left, ofs_right;

  chr_shift_ofs #(.SPAN(LINE_LEN)) u_ofs (
    .clk     (clk),
    .rst_n   (rst_sn),
    .clr_i   (ofs_clr),
    .left_i  (ofs_left),
    .right_i (ofs_right),
    .ofs_o   (shift_ofs)
  );

  // architectural state
  logic [AC_W-1:0] ac_q, ac_d;
  logic            pat_q, pat_d;
  logic            inc_q, inc_d;
  logic            sow_q, sow_d;
  logic            dsp_q, dsp_d;
  logic            cur_q, cur_d;
  logic            blk_q, blk_d;
  logic            wide_q, wide_d;
  logic            rows2_q, rows2_d;
  logic [1:0]      lum_q, lum_d;

  // strobe stage and response stage
  logic              st_we_q, st_we_d;
  logic              st_re_q, st_re_d;
  logic              st_acrd_q, st_acrd_d;
  logic              st_pat_q, st_pat_d;
  logic [AC_W-1:0]   st_addr_q, st_addr_d;
  logic [DATA_W-1:0] st_wdata_q, st_wdata_d;
  logic              st_wdata_en;
  logic              rsp_valid_q, rsp_ac_q, rsp_pat_q;
  logic [AC_W-1:0]   rsp_val_q;

  // counter stepping
  logic            accept, is_instr, is_move;
  logic            step_up, step_pat;
  logic [AC_W-1:0] ac_step;

  assign accept   = cmd_valid & ~fill_busy;
  assign is_instr = accept & ~cmd_is_data & ~cmd_is_read;
  assign is_move  = is_instr & (dec.op == OP_MOVE);
  assign step_up  = is_move ? dec.dir : inc_q;
  assign step_pat = is_move ? 1'b0 : pat_q;

  chr_addr_step #(
    .AC_W(AC_W), .PAT_W(PAT_W), .LINE_LEN(LINE_LEN),
    .LINE2_BASE(LINE2_BASE), .ONE_LINE_SPAN(ONE_LINE_SPAN)
  ) u_step (
    .ac_i       (ac_q),
    .pattern_i  (step_pat),
    .two_line_i (rows2_q),
    .up_i       (step_up),
    .nxt_o      (ac_step)
  );

  // next-state
  always_comb begin
    ac_d = ac_q;   pat_d = pat_q;  inc_d = inc_q;  sow_d = sow_q;
    dsp_d = dsp_q; cur_d = cur_q;  blk_d = blk_q;
    wide_d = wide_q; rows2_d = rows2_q; lum_d = lum_q;
    ofs_clr = 1'b0; ofs_left = 1'b0; ofs_right = 1'b0;
    fill_start = 1'b0;
    st_we_d = 1'b0; st_re_d = 1'b0; st_acrd_d = 1'b0; st_pat_d = 1'b0;
    st_addr_d = '0; st_wdata_d = st_wdata_q;

    if (fill_busy) begin
      st_we_d    = 1'b1;
      st_addr_d  = AC_W'(fill_addr);
      st_wdata_d = DATA_W'(FILL_CHAR);
    end else if (accept) begin
      if (cmd_is_data) begin
        ac_d      = ac_step;
        st_pat_d  = pat_q;
        st_addr_d = ac_q;
        if (cmd_is_read) begin
          st_re_d = 1'b1;
        end else begin
          st_we_d    = 1'b1;
          st_wdata_d = cmd_byte;
          if (sow_q && !pat_q) begin
            ofs_left  = inc_q;
            ofs_right = ~inc_q;
          end
        end
      end else if (cmd_is_read) begin
        st_acrd_d = 1'b1;
        st_addr_d = ac_q;
      end else begin
        unique case (dec.op)
          OP_CLEAR: begin
            fill_start = 1'b1;
            ac_d = '0; pat_d = 1'b0; inc_d = 1'b1; ofs_clr = 1'b1;
          end
          OP_HOME: begin
            ac_d = '0; pat_d = 1'b0; ofs_clr = 1'b1;
          end
          OP_ENTRY: begin
            inc_d = dec.inc; sow_d = dec.sow;
          end
          OP_APPEAR: begin
            dsp_d = dec.dsp; cur_d = dec.cur; blk_d = dec.blk;
          end
          OP_MOVE: begin
            ac_d  = ac_step;
            pat_d = 1'b0;
            if (dec.win) begin
              ofs_right = dec.dir;
              ofs_left  = ~dec.dir;
            end
          end
          OP_CONFIG: begin
            wide_d = dec.wide; rows2_d = dec.rows2; lum_d = dec.lum;
          end
          OP_PADDR: begin
            ac_d = AC_W'(dec.paddr); pat_d = 1'b1;
          end
          OP_DADDR: begin
            ac_d = AC_W'(dec.daddr); pat_d = 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign st_wdata_en = st_we_d;

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ac_q <= '0;  pat_q <= 1'b0; inc_q <= 1'b1; sow_q <= 1'b0;
      dsp_q <= 1'b0; cur_q <= 1'b0; blk_q <= 1'b0;
      wide_q <= 1'b1; rows2_q <= 1'b1; lum_q <= 2'b00;
    end else if (accept) begin
      ac_q <= ac_d;  pat_q <= pat_d; inc_q <= inc_d; sow_q <= sow_d;
      dsp_q <= dsp_d; cur_q <= cur_d; blk_q <= blk_d;
      wide_q <= wide_d; rows2_q <= rows2_d; lum_q <= lum_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_we_q <= 1'b0; st_re_q <= 1'b0; st_acrd_q <= 1'b0;
      st_pat_q <= 1'b0; st_addr_q <= '0;
      rsp_valid_q <= 1'b0; rsp_ac_q <= 1'b0; rsp_pat_q <= 1'b0;
      rsp_val_q <= '0;
    end else begin
      st_we_q     <= st_we_d;
      st_re_q     <= st_re_d;
      st_acrd_q   <= st_acrd_d;
      st_pat_q    <= st_pat_d;
      st_addr_q   <= st_addr_d;
      rsp_valid_q <= st_re_q | st_acrd_q;
      rsp_ac_q    <= st_acrd_q;
      rsp_pat_q   <= st_pat_q;
      rsp_val_q   <= st_addr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)          st_wdata_q <= '0;
    else if (st_wdata_en) st_wdata_q <= st_wdata_d;
  end

  // outputs
  assign busy              = fill_busy;
  assign dram_we           = st_we_q & ~st_pat_q;
  assign dram_re           = st_re_q & ~st_pat_q;
  assign pram_we           = st_we_q & st_pat_q;
  assign pram_re           = st_re_q & st_pat_q;
  assign dram_addr         = st_addr_q;
  assign pram_addr         = st_addr_q[PAT_W-1:0];
  assign mem_wdata         = st_wdata_q;
  assign rd_valid          = rsp_valid_q;
  assign rd_data           = rsp_ac_q  ? DATA_W'(rsp_val_q) :
                             rsp_pat_q ? pram_rdata : dram_rdata;
  assign cursor_addr       = ac_q;
  assign cursor_in_pattern = pat_q;
  assign incr_mode         = inc_q;
  assign shift_on_write    = sow_q;
  assign disp_on           = dsp_q;
  assign cursor_on         = cur_q;
  assign blink_on          = blk_q;
  assign bus_8bit          = wide_q;
  assign two_line          = rows2_q;
  assign bright            = lum_q;

  // assertions
  logic ac_in_rows;
  assign ac_in_rows = (ac_q <= ROW0_LAST) || (ac_q >= ROW1_FIRST && ac_q <= ROW1_LAST);

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    fill_busy |=> ($stable(ac_q) && $stable(cursor_on) && $stable(blink_on)));

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({dram_we, dram_re, pram_we, pram_re}));

  assert_read_reply_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    (dram_re || pram_re) |=> rd_valid);

  assert_row_range_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (accept && cmd_is_data && rows2_q && !pat_q && ac_in_rows) |=> ac_in_rows);

  assert_fill_strobe_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    fill_busy |=> (dram_we && mem_wdata == DATA_W'(FILL_CHAR)));

endmodule

// File: tb/chr_cmd_engine_tb.sv
module chr_cmd_engine_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic       cmd_valid, cmd_is_data, cmd_is_read;
  logic [7:0] cmd_byte;
  logic       busy, rd_valid;
  logic [7:0] rd_data;
  logic       dram_we, dram_re, pram_we, pram_re;
  logic [6:0] dram_addr;
  logic [5:0] pram_addr;
  logic [7:0] dram_rdata, pram_rdata, mem_wdata;
  logic [6:0] cursor_addr;
  logic       cursor_in_pattern;
  logic [5:0] shift_ofs;
  logic       incr_mode, shift_on_write, disp_on, cursor_on, blink_on;
  logic       bus_8bit, two_line;
  logic [1:0] bright;

  int n_chk = 0;
  int n_bad = 0;

  chr_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_is_data(cmd_is_data), .cmd_is_read(cmd_is_read),
    .cmd_byte(cmd_byte), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_we(dram_we), .dram_re(dram_re), .dram_addr(dram_addr), .dram_rdata(dram_rdata),
    .pram_we(pram_we), .pram_re(pram_re), .pram_addr(pram_addr), .pram_rdata(pram_rdata),
    .mem_wdata(mem_wdata), .cursor_addr(cursor_addr), .cursor_in_pattern(cursor_in_pattern),
    .shift_ofs(shift_ofs), .incr_mode(incr_mode), .shift_on_write(shift_on_write),
    .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on),
    .bus_8bit(bus_8bit), .two_line(two_line), .bright(bright)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // synchronous RAM models, one cycle read latency
  logic [7:0] dmem [128];
  logic [7:0] pmem [64];
  always_ff @(posedge clk) begin
    if (dram_we) dmem[dram_addr] <= mem_wdata;
    if (dram_re) dram_rdata <= dmem[dram_addr];
    if (pram_we) pmem[pram_addr] <= mem_wdata;
    if (pram_re) pram_rdata <= pmem[pram_addr];
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic d, input logic r, input logic [7:0] b);
    cmd_valid = 1'b1; cmd_is_data = d; cmd_is_read = r; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_is_data = 1'b0; cmd_is_read = 1'b0; cmd_byte = 8'h00;
  endtask

  task automatic instr(input logic [7:0] b); send(1'b0, 1'b0, b); endtask
  task automatic wr(input logic [7:0] b);    send(1'b1, 1'b0, b); endtask

  task automatic t_reset;
    chk("R1 ac", cursor_addr, 0);
    chk("R1 pattern", cursor_in_pattern, 0);
    chk("R1 ofs", shift_ofs, 0);
    chk("R1 inc", incr_mode, 1);
    chk("R1 sow", shift_on_write, 0);
    chk("R1 dsp/cur/blk", {disp_on, cursor_on, blink_on}, 0);
    chk("R1 wide", bus_8bit, 1);
    chk("R1 rows", two_line, 1);
    chk("R1 bright", bright, 0);
    chk("R1 busy", busy, 0);
    chk("R1 strobes", {dram_we, dram_re, pram_we, pram_re, rd_valid}, 0);
  endtask

  task automatic t_flags;
    instr(8'h3B);
    chk("R13 cfg a", {bus_8bit, two_line, bright}, 4'b1111);
    instr(8'h23);
    chk("R13 cfg b", {bus_8bit, two_line, bright}, 4'b0011);
    instr(8'h38);
    chk("R13 cfg c", {bus_8bit, two_line, bright}, 4'b1100);
    instr(8'h0F);
    chk("R13 appear a", {disp_on, cursor_on, blink_on}, 3'b111);
    instr(8'h0E);
    chk("R13 appear b", {disp_on, cursor_on, blink_on}, 3'b110);
    instr(8'h00);
    chk("R2 nop flags", {disp_on, cursor_on, blink_on, bus_8bit, two_line}, 5'b11011);
    chk("R2 nop ac", cursor_addr, 0);
  endtask

  task automatic t_two_row;
    instr(8'hA7);
    chk("R2 daddr", cursor_addr, 8'h27);
    wr(8'h41);
    chk("R5 we", {dram_we, pram_we}, 2'b10);
    chk("R5 addr", dram_addr, 8'h27);
    chk("R5 data", mem_wdata, 8'h41);
    chk("R3 27->40", cursor_addr, 8'h40);
    wr(8'h42);
    chk("R3 40->41", cursor_addr, 8'h41);
    instr(8'hE7); wr(8'h43);
    chk("R3 67->00", cursor_addr, 8'h00);
    instr(8'h04);
    instr(8'hC0); wr(8'h44);
    chk("R3 40->27", cursor_addr, 8'h27);
    instr(8'h80); wr(8'h45);
    chk("R3 00->67", cursor_addr, 8'h67);
    instr(8'h06);
  endtask

  task automatic t_one_row;
    instr(8'h30);
    chk("R13 one row", two_line, 0);
    instr(8'hCF); wr(8'h50);
    chk("R4 4F->00", cursor_addr, 8'h00);
    instr(8'h04); wr(8'h51);
    chk("R4 00->4F", cursor_addr, 8'h4F);
    instr(8'h06); instr(8'h38);
  endtask

  task automatic t_pattern;
    instr(8'h7F);
    chk("R2 paddr", {cursor_in_pattern, cursor_addr}, 8'hBF);
    wr(8'h1F);
    chk("R5 pattern we", {pram_we, dram_we}, 2'b10);
    chk("R5 pattern addr", pram_addr, 8'h3F);
    chk("R4 3F->00", cursor_addr, 8'h00);
    instr(8'h05); wr(8'h0A);
    chk("R4 00->3F", cursor_addr, 8'h3F);
    chk("R6 no shift pattern", shift_ofs, 0);
    instr(8'h06);
  endtask

  task automatic t_write_shift;
    instr(8'h02);
    instr(8'h07); instr(8'h80);
    wr(8'h61);
    chk("R6 left 1", shift_ofs, 1);
    wr(8'h62);
    chk("R6 left 2", shift_ofs, 2);
    instr(8'h05); wr(8'h63);
    chk("R6 right", shift_ofs, 1);
    chk("R6 ac", cursor_addr, 1);
    send(1'b1, 1'b1, 8'h00);
    chk("R6 read no shift", shift_ofs, 1);
    chk("R11 read step", cursor_addr, 0);
    instr(8'h06);
  endtask

  task automatic t_move;
    instr(8'h02);
    chk("R9 home", {cursor_addr, shift_ofs}, 0);
    chk("R9 keeps inc", incr_mode, 1);
    instr(8'h1C);
    chk("R7 ac up", cursor_addr, 1);
    chk("R12 0-1", shift_ofs, 39);
    instr(8'h18);
    chk("R7 ac down", cursor_addr, 0);
    chk("R12 39+1", shift_ofs, 0);
    instr(8'h14);
    chk("R7 cursor only", {cursor_addr, shift_ofs}, {7'd1, 6'd0});
    instr(8'h45); instr(8'h14);
    chk("R7 to display", {cursor_in_pattern, cursor_addr}, 8'h06);
  endtask

  task automatic t_ofs_mod;
    instr(8'h02); instr(8'h07); instr(8'h80);
    for (int i = 0; i < 39; i++) wr(8'h30);
    chk("R12 ofs 39", shift_ofs, 39);
    wr(8'h30);
    chk("R12 ofs wrap", shift_ofs, 0);
    chk("R3 ac after row", cursor_addr, 8'h40);
    instr(8'h06);
  endtask

  task automatic t_reads;
    instr(8'hC5);
    send(1'b0, 1'b1, 8'h00);
    chk("R10 not yet", rd_valid, 0);
    @(negedge clk);
    chk("R10 valid", rd_valid, 1);
    chk("R10 data", rd_data, 8'h45);
    instr(8'h90); wr(8'h5A);
    instr(8'h90); send(1'b1, 1'b1, 8'h00);
    chk("R11 re", {dram_re, dram_addr}, {1'b1, 7'h10});
    chk("R11 step", cursor_addr, 8'h11);
    @(negedge clk);
    chk("R11 dram data", {rd_valid, rd_data}, {1'b1, 8'h5A});
    instr(8'h42); wr(8'h15);
    instr(8'h42); send(1'b1, 1'b1, 8'h00);
    chk("R11 pram re", {pram_re, pram_addr}, {1'b1, 6'h02});
    @(negedge clk);
    chk("R11 pram data", {rd_valid, rd_data}, {1'b1, 8'h15});
  endtask

  task automatic t_clear;
    int nwr = 0;
    int nbusy = 0;
    int bad_wr = 0;
    instr(8'h04); instr(8'h18); instr(8'h97);
    instr(8'h01);
    chk("R8 ac", {cursor_in_pattern, cursor_addr}, 0);
    chk("R8 ofs", shift_ofs, 0);
    chk("R8 inc", incr_mode, 1);
    for (int i = 0; i < 134; i++) begin
      if (busy) nbusy++;
      if (dram_we) begin
        if (dram_addr != nwr[6:0] || mem_wdata != 8'h20) bad_wr++;
        nwr++;
      end
      if (i == 5)  begin cmd_valid = 1'b1; cmd_byte = 8'h0F; end
      if (i == 6)  begin cmd_valid = 1'b0; cmd_byte = 8'h00; end
      @(negedge clk);
    end
    chk("R8 busy cycles", nbusy, 128);
    chk("R8 fill writes", nwr, 128);
    chk("R8 fill order", bad_wr, 0);
    chk("R8 dropped cmd", {disp_on, cursor_on, blink_on}, 3'b110);
    chk("R8 mem 05", dmem[5], 8'h20);
    chk("R8 mem 7F", dmem[127], 8'h20);
    wr(8'h33);
    chk("R8 inc after", {dram_addr, cursor_addr}, {7'h00, 7'h01});
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_is_data = 1'b0; cmd_is_read = 1'b0;
    cmd_byte = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_flags;
    t_two_row;
    t_one_row;
    t_pattern;
    t_write_shift;
    t_move;
    t_ofs_mod;
    t_reads;
    t_clear;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule